// File: doc/BRIEF.md
# Register-Mapped GPIO Port Controller

This block manages three 8-bit general-purpose I/O ports from a byte-wide register bus. The bus has an 8-bit address, a write strobe and a read strobe. Each port has four registers: an output latch, a read-only view of the pin levels, and two mode registers called A and B. For each pin, the bit pair {B,A} picks one of four states. Three are input states, which differ only in pull-up strength (weak, strong or none). The fourth state drives the pin.

The block does not model the pads themselves. It gives the pad logic registered per-pin controls: output enable, output data, and the weak and strong pull-up selects. Pad inputs go through a two-flop synchronizer. A read of an input register returns the synchronized level in the same cycle as the read strobe. Nothing is held from an earlier moment.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, all output latches and all A registers read 0x00. The B registers of ports 0 and 1 read 0x00. The port 2 B register reads 0x1F, so port 2 pins 0 to 4 are inputs with no pull-up and every other pin is an input with weak pull-up.
- R2: The pin mode is {B,A}. 00 selects input with weak pull-up (pad_pu_weak=1). 01 selects input with strong pull-up (pad_pu_strong=1). 10 selects input with no pull-up (both pulls 0). 11 selects output (pad_oe=1). A driven pin never has a pull-up asserted.
- R3: Bit i of a port's A and B registers controls only pin i of that port. Pin i of port p sits at bit p*8+i of each pad bus.
- R4: The register addresses are as follows. Port 0 uses 0xE4 (output), 0xE5 (input), 0xE6 (A) and 0xE7 (B). Port 1 uses 0xE0, 0xE1, 0xE2 and 0xE3. Port 2 uses 0xDC, 0xDD, 0xDE and 0xDF. The output, A and B registers read back the last value written.
- R5: pad_out carries the latched output bit only when the pin is in mode 11. In every other mode it is 0.
- R6: A read of an input address returns the port's pad levels as seen through a two-flop synchronizer. A level that has been stable for three clocks is returned, and a later change is returned by the next read.
- R7: A write to an input address, or to any address outside the twelve mapped ones, changes no register and no pad output.
- R8: A read of an unmapped address returns 0x00. bus_rdata is 0x00 whenever bus_rd is low.
- R9: When a read and a write to the same register occur in one cycle, the read returns the value held before the write. A read in the following cycle returns the new value.
- R10: The pad control outputs are registered. They show a register write one clock after the edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle bus_rd is high |
| pad_in | input | 24 | Pad input levels, port p at bits p*8+7:p*8 |
| pad_oe | output | 24 | Per-pin output enable |
| pad_out | output | 24 | Per-pin output data |
| pad_pu_weak | output | 24 | Per-pin weak pull-up select |
| pad_pu_strong | output | 24 | Per-pin strong pull-up select |

## Verification
The collision that matters is a bus read and a bus write to the same register in one cycle. The bench raises both strobes together on an output latch and on a mode register. It expects the read data to show the value held before the write, and a read in the next cycle to show the new value. A second overlap involves the pads. A mode write lands while the pad outputs still show the previous configuration. The bench checks the pads just after the storing edge, expecting the old values, and again one clock later, expecting the new ones.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    PM_IN_WEAK   = 2'b00,
    PM_IN_STRONG = 2'b01,
    PM_IN_FLOAT  = 2'b10,
    PM_DRIVE     = 2'b11
  } pin_mode_e;

  // Register offsets inside one port's 4-byte window
  localparam logic [1:0] OFS_OUT  = 2'd0;
  localparam logic [1:0] OFS_IN   = 2'd1;
  localparam logic [1:0] OFS_CTLA = 2'd2;
  localparam logic [1:0] OFS_CTLB = 2'd3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] stage1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      d_sync   <= '0;
    end else begin
      stage1_q <= d_in;
      d_sync   <= stage1_q;
    end
  end
endmodule

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg
  import gpio_pkg::*;
(
  input  logic ctl_b,
  input  logic ctl_a,
  input  logic latch_bit,
  output logic oe,
  output logic dout,
  output logic pu_weak,
  output logic pu_strong
);
  pin_mode_e mode;

  always_comb begin
    mode      = pin_mode_e'({ctl_b, ctl_a});
    oe        = 1'b0;
    dout      = 1'b0;
    pu_weak   = 1'b0;
    pu_strong = 1'b0;
    case (mode)
      PM_IN_WEAK:   pu_weak   = 1'b1;
      PM_IN_STRONG: pu_strong = 1'b1;
      PM_IN_FLOAT:  ;
      PM_DRIVE: begin
        oe   = 1'b1;
        dout = latch_bit;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int               W     = 8,
  parameter logic [W-1:0]     RST_B = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_out,
  input  logic         wr_a,
  input  logic         wr_b,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] out_q,
  output logic [W-1:0] ctl_a_q,
  output logic [W-1:0] ctl_b_q,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_do,
  output logic [W-1:0] pad_wpu,
  output logic [W-1:0] pad_spu
);
  logic [W-1:0] oe_d, do_d, wpu_d, spu_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= '0;
      ctl_a_q <= '0;
      ctl_b_q <= RST_B;
    end else begin
      if (wr_out) out_q   <= wdata;
      if (wr_a)   ctl_a_q <= wdata;
      if (wr_b)   ctl_b_q <= wdata;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    gpio_pin_cfg u_cfg (
      .ctl_b     (ctl_b_q[i]),
      .ctl_a     (ctl_a_q[i]),
      .latch_bit (out_q[i]),
      .oe        (oe_d[i]),
      .dout      (do_d[i]),
      .pu_weak   (wpu_d[i]),
      .pu_strong (spu_d[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe  <= '0;
      pad_do  <= '0;
      pad_wpu <= ~RST_B;
      pad_spu <= '0;
    end else begin
      pad_oe  <= oe_d;
      pad_do  <= do_d;
      pad_wpu <= wpu_d;
      pad_spu <= spu_d;
    end
  end

  // R1
  rst_defaults_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_q == '0 && ctl_a_q == '0 && ctl_b_q == RST_B));

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_out |=> $stable(out_q));

  // R2
  pull_vs_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & (pad_wpu | pad_spu)) == '0);

  // R5
  drive_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_do & ~pad_oe) == '0);

  // R10
  pad_lag_chk: assert property (@(posedge clk) disable iff (rst)
    ($stable(ctl_a_q) && $stable(ctl_b_q)) |=> $stable(pad_oe));
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int                          NUM_PORTS = 3,
  parameter int                          PORT_W    = 8,
  parameter int                          ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]           TOP_BASE  = 8'hE4,
  parameter logic [NUM_PORTS*PORT_W-1:0] CTLB_RST  = 24'h1F_00_00
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [PORT_W-1:0]             bus_wdata,
  output logic [PORT_W-1:0]             bus_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0]   pad_in,
  output logic [NUM_PORTS*PORT_W-1:0]   pad_oe,
  output logic [NUM_PORTS*PORT_W-1:0]   pad_out,
  output logic [NUM_PORTS*PORT_W-1:0]   pad_pu_weak,
  output logic [NUM_PORTS*PORT_W-1:0]   pad_pu_strong
);
  localparam int PINS   = NUM_PORTS * PORT_W;
  localparam int IDX_W  = ADDR_W - 2;
  localparam logic [IDX_W-1:0] TOP_IDX = TOP_BASE[ADDR_W-1:2];

  logic [PINS-1:0]      pin_sync;
  logic [NUM_PORTS-1:0] hit;
  logic [1:0]           ofs;
  logic [PORT_W-1:0]    out_arr  [NUM_PORTS];
  logic [PORT_W-1:0]    ctla_arr [NUM_PORTS];
  logic [PORT_W-1:0]    ctlb_arr [NUM_PORTS];
  logic [PORT_W-1:0]    rd_mux;

  assign ofs = bus_addr[1:0];

  gpio_sync #(.WIDTH(PINS)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_in   (pad_in),
    .d_sync (pin_sync)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [IDX_W-1:0] MY_IDX = TOP_IDX - IDX_W'(p);
    assign hit[p] = (bus_addr[ADDR_W-1:2] == MY_IDX);

    gpio_port #(
      .W     (PORT_W),
      .RST_B (CTLB_RST[p*PORT_W +: PORT_W])
    ) u_port (
      .clk     (clk),
      .rst     (rst),
      .wr_out  (bus_wr && hit[p] && ofs == OFS_OUT),
      .wr_a    (bus_wr && hit[p] && ofs == OFS_CTLA),
      .wr_b    (bus_wr && hit[p] && ofs == OFS_CTLB),
      .wdata   (bus_wdata),
      .out_q   (out_arr[p]),
      .ctl_a_q (ctla_arr[p]),
      .ctl_b_q (ctlb_arr[p]),
      .pad_oe  (pad_oe[p*PORT_W +: PORT_W]),
      .pad_do  (pad_out[p*PORT_W +: PORT_W]),
      .pad_wpu (pad_pu_weak[p*PORT_W +: PORT_W]),
      .pad_spu (pad_pu_strong[p*PORT_W +: PORT_W])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (hit[p]) begin
        case (ofs)
          OFS_OUT:  rd_mux = out_arr[p];
          OFS_IN:   rd_mux = pin_sync[p*PORT_W +: PORT_W];
          OFS_CTLA: rd_mux = ctla_arr[p];
          default:  rd_mux = ctlb_arr[p];
        endcase
      end
    end
  end

  assign bus_rdata = bus_rd ? rd_mux : '0;

  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd || hit == '0) |-> bus_rdata == '0);

  // R6
  in_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && hit[0] && ofs == OFS_IN) |-> bus_rdata == pin_sync[PORT_W-1:0]);
endmodule

// File: tb/sim_gpio_ctrl.sv
module sim_gpio_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [23:0] pad_in = '0;
  logic [23:0] pad_oe, pad_out, pad_pu_weak, pad_pu_strong;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] m_out [3];
  logic [7:0] m_a   [3];
  logic [7:0] m_b   [3];

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #10 clk = ~clk;

  gpio_ctrl u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu_weak(pad_pu_weak),
    .pad_pu_strong(pad_pu_strong)
  );

  function automatic int port_of(input logic [7:0] a);
    if (a >= 8'hE4 && a <= 8'hE7) return 0;
    if (a >= 8'hE0 && a <= 8'hE3) return 1;
    if (a >= 8'hDC && a <= 8'hDF) return 2;
    return -1;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    int p = port_of(a);
    if (p < 0) return 8'h00;
    case (a[1:0])
      2'd0: return m_out[p];
      2'd1: return pad_in[p*8 +: 8];
      2'd2: return m_a[p];
      default: return m_b[p];
    endcase
  endfunction

  task automatic model_apply(input logic [7:0] a, input logic [7:0] d);
    int p = port_of(a);
    if (p >= 0) begin
      case (a[1:0])
        2'd0: m_out[p] = d;
        2'd2: m_a[p]   = d;
        2'd3: m_b[p]   = d;
        default: ;
      endcase
    end
  endtask

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_pads(input string tag);
    logic [23:0] e_oe, e_do, e_w, e_s;
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 8; i++) begin
        logic [1:0] m;
        m = {m_b[p][i], m_a[p][i]};
        e_oe[p*8+i] = (m == 2'b11);
        e_do[p*8+i] = (m == 2'b11) & m_out[p][i];
        e_w[p*8+i]  = (m == 2'b00);
        e_s[p*8+i]  = (m == 2'b01);
      end
    end
    check({tag, " oe"},     pad_oe, e_oe);
    check({tag, " out"},    pad_out, e_do);
    check({tag, " weak"},   pad_pu_weak, e_w);
    check({tag, " strong"}, pad_pu_strong, e_s);
  endtask

  task automatic wr_raw(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #2;
    bus_wr = 1'b0;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    wr_raw(a, d);
    model_apply(a, d);
  endtask

  task automatic bus_read(input logic [7:0] a, input string tag);
    @(posedge clk); #2;
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp_rd(a));
    tag_q.push_back(tag);
    @(posedge clk); #2;
    bus_rd = 1'b0;
  endtask

  // Read and write the same register in one cycle
  task automatic bus_rw(input logic [7:0] a, input logic [7:0] d, input string tag);
    @(posedge clk); #2;
    bus_addr = a; bus_wdata = d; bus_rd = 1'b1; bus_wr = 1'b1;
    exp_q.push_back(exp_rd(a));
    tag_q.push_back(tag);
    @(posedge clk); #2;
    bus_rd = 1'b0; bus_wr = 1'b0;
    model_apply(a, d);
  endtask

  // Monitor: pops expected read data mid-cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_rd) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL scoreboard underflow actual=%h expected=none", bus_rdata);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, {16'h0, bus_rdata}, {16'h0, e});
        end
      end else begin
        check("R8 idle rdata", {16'h0, bus_rdata}, 24'h0);
      end
    end
  end

  initial begin
    #3_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int p = 0; p < 3; p++) begin
      m_out[p] = 8'h00; m_a[p] = 8'h00; m_b[p] = 8'h00;
    end
    m_b[2] = 8'h1F;
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    @(posedge clk); #2;

    // R1 reset state
    check_pads("R1 reset pads");
    for (int a = 8'hDC; a <= 8'hE7; a++) bus_read(8'(a), "R1 reset readback");

    // R2 R3 R5: all four modes across port 0 pins
    bus_write(8'hE4, 8'hFF);
    bus_write(8'hE6, 8'hAA);
    bus_write(8'hE7, 8'hCC);
    repeat (2) @(posedge clk); #2;
    check_pads("R2 R3 R5 mixed modes");
    check("R2 p0 oe pattern", {16'h0, pad_oe[7:0]}, 24'h88);

    // R4 R5: port 1 fully driven, port 2 reconfigured
    bus_write(8'hE0, 8'h5A);
    bus_write(8'hE2, 8'hFF);
    bus_write(8'hE3, 8'hFF);
    bus_write(8'hDE, 8'h0F);
    bus_write(8'hDC, 8'h3C);
    repeat (2) @(posedge clk); #2;
    check_pads("R4 R5 port map");
    check("R5 p1 drive", {16'h0, pad_out[15:8]}, 24'h5A);
    for (int a = 8'hDC; a <= 8'hE7; a++) bus_read(8'(a), "R4 readback");

    // R6 input sampling
    pad_in = 24'hA5_3C_96;
    repeat (3) @(posedge clk);
    bus_read(8'hE5, "R6 p0 in");
    bus_read(8'hE1, "R6 p1 in");
    bus_read(8'hDD, "R6 p2 in");
    pad_in = 24'h18_C3_7E;
    repeat (3) @(posedge clk);
    bus_read(8'hE5, "R6 p0 in changed");
    bus_read(8'hE1, "R6 p1 in changed");
    bus_read(8'hDD, "R6 p2 in changed");

    // R7 ignored writes
    wr_raw(8'hE5, 8'h00);
    wr_raw(8'hDD, 8'hFF);
    wr_raw(8'h10, 8'hFF);
    wr_raw(8'hE8, 8'h00);
    wr_raw(8'hDB, 8'h00);
    repeat (2) @(posedge clk); #2;
    check_pads("R7 pads unchanged");
    for (int a = 8'hDC; a <= 8'hE7; a++) bus_read(8'(a), "R7 regs unchanged");

    // R8 unmapped reads
    bus_read(8'h00, "R8 unmapped 00");
    bus_read(8'hDB, "R8 unmapped DB");
    bus_read(8'hE8, "R8 unmapped E8");
    bus_read(8'hFF, "R8 unmapped FF");

    // R9 same-cycle read and write
    bus_rw(8'hE4, 8'h33, "R9 rw old out");
    bus_read(8'hE4, "R9 new out");
    bus_rw(8'hDF, 8'hA0, "R9 rw old ctlB");
    bus_read(8'hDF, "R9 new ctlB");

    // R10 one-clock lag of pad controls
    repeat (2) @(posedge clk); #2;
    wr_raw(8'hE7, 8'h00);
    check_pads("R10 before lag");
    model_apply(8'hE7, 8'h00);
    @(posedge clk); #2;
    check_pads("R10 after lag");

    repeat (3) @(posedge clk); #2;
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule